// File: doc/BRIEF.md
# Add/Subtract ALU with Status Flags

This block is the add/subtract slice of a 32-bit integer execution stage. It takes two operands, an operation code and the processor's current status word. One clock later it returns the result, a write-enable for the destination register and the updated status word. It covers plain addition, subtraction in both operand orders, comparison, and addition and subtraction that saturate.

For every arithmetic operation, four condition flags are cleared and then recomputed: zero, sign, carry/borrow and overflow. When a non-saturating operation overflows, the sign flag reports the true sign of the exact result rather than bit 31 of the wrapped result. The saturating forms clamp the result to the signed limits and OR their overflow into a sticky saturation flag. Every other status bit passes through unchanged. A new operation can be issued on every clock.

Top module: `addsub_flag_alu`

## Requirements
- R1: While `rst_n` is low, and on the first clock after reset, `result` is 0, `wr_en` is 0 and `status_out` is 0.
- R2: The outputs are registered. Inputs sampled at a rising clock edge appear on the outputs just after that edge and stay stable until the next edge. One operation is accepted per cycle.
- R3: Operation code 0 (add) writes `opa + opb`. CY is the carry out of bit 31. OV is set when both operands have the same sign and the result's sign differs from it. Z is set when the result is zero. S is result bit 31 XOR OV.
- R4: Operation code 1 (subtract) writes `opb - opa`. CY is set when `opb` is unsigned-less-than `opa`. OV is set when the operand signs differ and the result's sign differs from that of `opb`. Z is set when the result is zero. S is result bit 31 XOR OV.
- R5: Operation code 2 (reverse subtract) writes `opa - opb`. CY is set when `opa` is unsigned-less-than `opb`. OV is set when the operand signs differ and the result's sign differs from that of `opa`. Z and S follow the rule of R4.
- R6: Operation code 3 (compare) sets the four flags exactly as operation code 1 does, but holds `wr_en` low.
- R7: Operation code 4 (saturating add) forms `opa + opb`. On overflow the result clamps to 0x7FFFFFFF if both operands are non-negative and to 0x80000000 otherwise. CY is set when the wrapped sum is unsigned-less-than `opa`. OV follows the rule of R3. Z and S are taken from the clamped result, with no sign inversion.
- R8: Operation code 5 (saturating subtract) forms `opb - opa`. On overflow the result clamps to 0x7FFFFFFF if `opb` is non-negative and to 0x80000000 otherwise. CY and OV follow the rules of R4. Z and S are taken from the clamped result.
- R9: The SAT flag is sticky. Operation codes 4 and 5 OR their OV into it, and every other operation code passes it through from `status_in`.
- R10: The status bit positions are Z = bit 0, S = bit 1, OV = bit 2, CY = bit 3 and SAT = bit 4. Every status bit at position 5 and above is copied unchanged from `status_in` to `status_out`.
- R11: Operation codes 6 and 7 are reserved. They give `result` 0 and `wr_en` 0, and copy `status_in` to `status_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 reverse sub, 3 compare, 4 sat add, 5 sat sub) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| status_in | input | 32 | Current status word |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Result write-enable |
| status_out | output | 32 | Registered updated status word |

## Verification
The block holds no state beyond its output registers. Any fault in a flag equation therefore appears at `status_out` one clock after the operand pair that exposes it.

The faults most likely to hide are the ones that only specific operand pairs trigger:
- a missing sign inversion or a swapped borrow sense needs operands that overflow or that straddle unsigned order;
- a lost sticky SAT needs an incoming SAT of 1 on an operation that does not overflow;
- a wrong clamp polarity needs overflow toward each signed limit.

Random operands cover the broad equations. Directed cases force the limits, the zero results and the reserved codes, each of which shows at the ports on the next cycle.

// File: rtl/addsub_flag_alu.sv
module addsub_flag_alu #(
  parameter int W       = 32,
  parameter int SW      = 32,
  parameter int Z_BIT   = 0,
  parameter int S_BIT   = 1,
  parameter int OV_BIT  = 2,
  parameter int CY_BIT  = 3,
  parameter int SAT_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_sel,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [SW-1:0] status_in,
  output logic [W-1:0]  result,
  output logic          wr_en,
  output logic [SW-1:0] status_out
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};
  localparam logic [SW-1:0] ARITH_MASK =
    (SW'(1) << Z_BIT) | (SW'(1) << S_BIT) | (SW'(1) << OV_BIT) | (SW'(1) << CY_BIT);

  logic [W:0] sum_ab, dif_ba, dif_ab;
  logic       ov_add, ov_ba, ov_ab;

  assign sum_ab = {1'b0, opa} + {1'b0, opb};
  assign dif_ba = {1'b0, opb} - {1'b0, opa};
  assign dif_ab = {1'b0, opa} - {1'b0, opb};

  assign ov_add = (opa[MSB] == opb[MSB]) && (sum_ab[MSB] != opa[MSB]);
  assign ov_ba  = (opa[MSB] != opb[MSB]) && (dif_ba[MSB] != opb[MSB]);
  assign ov_ab  = (opa[MSB] != opb[MSB]) && (dif_ab[MSB] != opa[MSB]);

  logic [W-1:0]  res_n;
  logic          wr_n, arith, sat_op, f_cy, f_ov, f_s, inv_s;
  logic [SW-1:0] st_n;

  always_comb begin
    res_n  = '0;
    wr_n   = 1'b0;
    arith  = 1'b1;
    sat_op = 1'b0;
    inv_s  = 1'b1;
    f_cy   = 1'b0;
    f_ov   = 1'b0;
    case (op_sel)
      3'd0: begin
        res_n = sum_ab[W-1:0]; wr_n = 1'b1;
        f_cy  = sum_ab[W];     f_ov = ov_add;
      end
      3'd1: begin
        res_n = dif_ba[W-1:0]; wr_n = 1'b1;
        f_cy  = dif_ba[W];     f_ov = ov_ba;
      end
      3'd2: begin
        res_n = dif_ab[W-1:0]; wr_n = 1'b1;
        f_cy  = dif_ab[W];     f_ov = ov_ab;
      end
      3'd3: begin
        res_n = dif_ba[W-1:0];
        f_cy  = dif_ba[W];     f_ov = ov_ba;
      end
      3'd4: begin
        wr_n  = 1'b1; sat_op = 1'b1; inv_s = 1'b0;
        f_ov  = ov_add;
        f_cy  = sum_ab[W-1:0] < opa;
        res_n = ov_add ? (opa[MSB] ? NEG_LIM : POS_LIM) : sum_ab[W-1:0];
      end
      3'd5: begin
        wr_n  = 1'b1; sat_op = 1'b1; inv_s = 1'b0;
        f_ov  = ov_ba;
        f_cy  = dif_ba[W];
        res_n = ov_ba ? (opb[MSB] ? NEG_LIM : POS_LIM) : dif_ba[W-1:0];
      end
      default: arith = 1'b0;
    endcase
  end

  assign f_s = res_n[MSB] ^ (inv_s & f_ov);

  always_comb begin
    st_n = status_in;
    if (arith) begin
      st_n = status_in & ~ARITH_MASK;
      st_n[Z_BIT]  = (res_n == '0);
      st_n[S_BIT]  = f_s;
      st_n[OV_BIT] = f_ov;
      st_n[CY_BIT] = f_cy;
      st_n[SAT_BIT] = status_in[SAT_BIT] | (sat_op & f_ov);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result     <= '0;
      wr_en      <= 1'b0;
      status_out <= '0;
    end else begin
      result     <= res_n;
      wr_en      <= wr_n;
      status_out <= st_n;
    end
  end
endmodule

// File: rtl/addsub_flag_alu_chk.sv
module addsub_flag_alu_chk #(
  parameter int W       = 32,
  parameter int SW      = 32,
  parameter int Z_BIT   = 0,
  parameter int OV_BIT  = 2,
  parameter int SAT_BIT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_sel,
  input logic [SW-1:0] status_in,
  input logic [W-1:0]  result,
  input logic          wr_en,
  input logic [SW-1:0] status_out
);
  localparam logic [SW-1:0] KEEP = ~((SW'(1) << (SAT_BIT + 1)) - SW'(1));
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_sel) == 3'd3) |-> !wr_en);

  assert_keep_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status_out & KEEP) == ($past(status_in) & KEEP)));

  assert_sat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(status_in[SAT_BIT])) |-> status_out[SAT_BIT]);

  assert_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(op_sel) == 3'd4 || $past(op_sel) == 3'd5) && status_out[OV_BIT])
      |-> (result == POS_LIM || result == NEG_LIM));

  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wr_en) |-> (status_out[Z_BIT] == (result == '0)));

  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_sel) >= 3'd6) |-> (!wr_en && status_out == $past(status_in)));

  assert_reset_R1: assert property (@(posedge clk)
    !$past(rst_n) |-> (!wr_en && result == '0 && status_out == '0));
endmodule

bind addsub_flag_alu addsub_flag_alu_chk #(
  .W(W), .SW(SW), .Z_BIT(Z_BIT), .OV_BIT(OV_BIT), .SAT_BIT(SAT_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .status_in(status_in),
  .result(result), .wr_en(wr_en), .status_out(status_out)
);

// File: tb/sim_addsub_flag_alu.sv
`timescale 1ns/1ps
module sim_addsub_flag_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] opa = '0, opb = '0, status_in = '0;
  logic [31:0] result, status_out;
  logic        wr_en;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  addsub_flag_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opa(opa), .opb(opb),
    .status_in(status_in), .result(result), .wr_en(wr_en), .status_out(status_out)
  );

  function automatic bit sovf(longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  // returns {wr, result, status}
  function automatic logic [64:0] model(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                                        logic [31:0] st);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint sv;
    logic [63:0] full;
    logic [31:0] r;
    bit wr, cy, ov, s, satop;
    satop = 0; wr = 1;
    case (op)
      3'd0: begin full = {32'd0, a} + {32'd0, b}; r = full[31:0]; cy = full[32];
                  sv = sa + sb; end
      3'd1, 3'd3: begin r = b - a; cy = (b < a); sv = sb - sa; wr = (op == 3'd1); end
      3'd2: begin r = a - b; cy = (a < b); sv = sa - sb; end
      3'd4: begin sv = sa + sb; r = a + b; cy = (r < a); satop = 1; end
      3'd5: begin sv = sb - sa; r = b - a; cy = (b < a); satop = 1; end
      default: return {1'b0, 32'd0, st};
    endcase
    ov = sovf(sv);
    if (satop) begin
      if (ov) r = (sv > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
      s = r[31];
    end else s = r[31] ^ ov;
    st = (st & ~32'hF) | {28'd0, cy, ov, s, (r == 0)};
    if (satop && ov) st[4] = 1'b1;
    return {wr, r, st};
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R3"; 3'd1: return "R4"; 3'd2: return "R5"; 3'd3: return "R6";
      3'd4: return "R7"; 3'd5: return "R8"; default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [2:0] op, logic [31:0] a, logic [31:0] b, logic [31:0] st);
    logic [64:0] e;
    @(negedge clk);
    op_sel = op; opa = a; opb = b; status_in = st;
    e = model(op, a, b, st);
    @(posedge clk); #1;
    check(tag_of(op), {31'd0, wr_en, result}, {31'd0, e[64], e[63:32]});
    check(tag_of(op), {32'd0, status_out}, {32'd0, e[31:0]});
    check("R10", {32'd0, status_out & 32'hFFFF_FFE0}, {32'd0, st & 32'hFFFF_FFE0});
    if (op != 3'd4 && op != 3'd5)
      check("R9", {63'd0, status_out[4]}, {63'd0, st[4]});
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] prev_r;
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {31'd0, wr_en, result}, 64'd0);
    check("R1", {32'd0, status_out}, 64'd0);
    @(negedge clk);
    op_sel = 3'd0; opa = 32'd5; opb = 32'd7; status_in = 32'h0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R2", {32'd0, result}, 64'd12);
    @(negedge clk);
    prev_r = result;
    opa = 32'd100;
    #1;
    check("R2", {32'd0, result}, {32'd0, prev_r});
    @(posedge clk); #1;
    check("R2", {32'd0, result}, 64'd107);

    run_op(3'd0, 32'h7FFF_FFFF, 32'h1, 32'h0);
    run_op(3'd0, 32'h0, 32'h0, 32'hF);
    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 32'h0);
    run_op(3'd1, 32'h1, 32'h0, 32'h0);
    run_op(3'd1, 32'h1, 32'h8000_0000, 32'h0);
    run_op(3'd2, 32'h0, 32'h1, 32'hAB00_0000);
    run_op(3'd2, 32'h8000_0000, 32'h1, 32'h0);
    run_op(3'd3, 32'h1234, 32'h1234, 32'h0);
    run_op(3'd3, 32'h7FFF_FFFF, 32'h8000_0000, 32'h10);
    run_op(3'd4, 32'h7FFF_FFFF, 32'h1, 32'h0);
    run_op(3'd4, 32'h8000_0000, 32'h8000_0000, 32'h0);
    run_op(3'd4, 32'h3, 32'h4, 32'h10);
    run_op(3'd4, 32'hFFFF_FFFF, 32'h1, 32'h0);
    run_op(3'd5, 32'h1, 32'h8000_0000, 32'h0);
    run_op(3'd5, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0);
    run_op(3'd5, 32'h9, 32'h9, 32'h10);
    run_op(3'd0, 32'h7FFF_FFFF, 32'h1, 32'h10);
    run_op(3'd6, 32'h5, 32'h6, 32'hDEAD_BEEF);
    run_op(3'd7, 32'h7FFF_FFFF, 32'h1, 32'h1234_5670);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if ((i % 7) == 0) a = {a[31], 31'h7FFF_FFFF};
      if ((i % 11) == 0) b = a;
      run_op(3'($urandom_range(0, 7)), a, b, $urandom);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule